// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block takes a programmable target device through its serial configuration handshake. It drives three pins towards the device (an active-low program strobe, a configuration clock and a configuration data line) and watches two pins coming back from it: an init indication and a done indication. A single start pulse runs the whole sequence. The block holds program low until init falls, then releases program and waits for init to rise. It then shifts serial bits out, one at a time, and finally waits for done.

Configuration bits come from an upstream expander over a valid/ready handshake. The bit that carries the last flag closes the data phase. Each of the three waits has its own timeout, counted in system clocks, and its own error code. Busy, success and the 2-bit error code are held until the next start. Each bit is sent as four equal steps. The length of a step, the timeout and the depth of the input synchronizers are parameters.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, and whenever the block is not busy, the program, clock and data pins are all high. After reset, busy, ok and bit_ready are low and err is 00.
- R2: A start pulse seen while idle raises busy and drives program low in the next cycle. All other pins stay high.
- R3: Once the synchronized init input is seen low, program is driven high again and the block waits for init to return high.
- R4: Each accepted bit is sent in four steps of STEP_CLKS cycles each, in this order: clock low with data high, clock low with data equal to the bit, clock high with data equal to the bit, clock high with data high. Bits leave in the order they were accepted.
- R5: bit_ready is high only in the data phase, while no bit is being sent and before the last bit has been accepted. Once the bit flagged as last has been sent, the block waits for done.
- R6: When done is seen high in the final wait, busy falls, ok rises and err stays 00. These values hold until the next start.
- R7: A wait that lasts TIMEOUT_CLKS cycles without its condition ends the run with busy low and ok low. err reads 01 when init did not fall, 10 when init did not rise, and 11 when done did not rise.
- R8: init and done pass through SYNC_STAGES flip-flops before use. If a wait condition is seen in the final cycle of its timeout window, the condition wins over the timeout.
- R9: A start pulse while busy is ignored. The running sequence and its pins are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a configuration run |
| bit_valid_i | input | 1 | A configuration bit is offered |
| bit_data_i | input | 1 | Value of the offered bit |
| bit_last_i | input | 1 | The offered bit is the final one |
| bit_ready_o | output | 1 | The sequencer takes the offered bit this cycle |
| dev_init_i | input | 1 | Init indication from the target (asynchronous) |
| dev_done_i | input | 1 | Done indication from the target (asynchronous) |
| prog_n_o | output | 1 | Active-low program strobe to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| cdata_o | output | 1 | Configuration data to the target |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | The last run finished with done high |
| err_o | output | 2 | Error code of the last run (00 none) |

## Verification
Two events can land in the same cycle: a wait stage's timeout counter reaching its limit, and the awaited pin edge arriving through the synchronizer. The bench counts clock edges from the accepted start pulse. It drops init so that the synchronized level first appears in the last cycle of the window, and in a second run one cycle later. The first run must move on to the release stage and later end with code 10. The second must end with code 01.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_LO,
    ST_PROG_HI,
    ST_SHIFT,
    ST_DONE_WT
  } seq_st_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_INIT_LO = 2'd1,
    ERR_INIT_HI = 2'd2,
    ERR_DONE    = 2'd3
  } seq_err_t;

  typedef enum logic [1:0] {
    PH_CLK_LO,
    PH_DATA,
    PH_CLK_HI,
    PH_RESTORE
  } bit_ph_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic src;
    if (i == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = sr[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[i] <= RST_VAL;
      else        sr[i] <= src;
    end
  end

  assign q_o = sr[STAGES-1];

endmodule

// File: rtl/cfg_tmo.sv
module cfg_tmo #(
  parameter int LIMIT = 700000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit_o = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (en_i && !hit_o)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfg_bit_tx.sv
module cfg_bit_tx
  import cfg_load_pkg::*;
#(
  parameter int STEP_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic bit_i,
  input  logic last_i,
  output logic busy_o,
  output logic last_fin_o,
  output logic cclk_o,
  output logic cdata_o
);

  localparam int SW = (STEP_CLKS > 2) ? $clog2(STEP_CLKS) : 1;

  logic          act_q, act_d;
  bit_ph_t       ph_q, ph_d;
  logic [SW-1:0] stp_q, stp_d;
  logic          bit_q, bit_d;
  logic          last_q, last_d;
  logic          stp_end;

  assign stp_end = (stp_q == SW'(STEP_CLKS - 1));

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    stp_d  = stp_q;
    bit_d  = bit_q;
    last_d = last_q;
    if (!act_q) begin
      if (load_i) begin
        act_d  = 1'b1;
        ph_d   = PH_CLK_LO;
        stp_d  = '0;
        bit_d  = bit_i;
        last_d = last_i;
      end
    end else if (stp_end) begin
      stp_d = '0;
      if (ph_q == PH_RESTORE) act_d = 1'b0;
      else                    ph_d  = bit_ph_t'(ph_q + 2'd1);
    end else begin
      stp_d = stp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= PH_CLK_LO;
      stp_q  <= '0;
      bit_q  <= 1'b1;
      last_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      stp_q  <= stp_d;
      bit_q  <= bit_d;
      last_q <= last_d;
    end
  end

  assign busy_o     = act_q;
  assign last_fin_o = act_q && (ph_q == PH_RESTORE) && stp_end && last_q;
  assign cclk_o     = !act_q || (ph_q == PH_CLK_HI) || (ph_q == PH_RESTORE);
  assign cdata_o    = (!act_q || (ph_q == PH_CLK_LO) || (ph_q == PH_RESTORE)) ? 1'b1 : bit_q;

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int STEP_CLKS    = 4,
  parameter int TIMEOUT_CLKS = 700000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  input  logic       dev_init_i,
  input  logic       dev_done_i,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       cdata_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);

  seq_st_t  st_q, st_d;
  seq_err_t err_q, err_d;
  logic     ok_q, ok_d;
  logic     lastacc_q, lastacc_d;

  logic init_s, done_s;
  logic tmo_hit, tmo_en, tmo_clr;
  logic tx_busy, tx_last_fin, accept;

  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d_i(dev_init_i), .q_o(init_s)
  );

  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d_i(dev_done_i), .q_o(done_s)
  );

  assign tmo_en  = (st_q == ST_PROG_LO) || (st_q == ST_PROG_HI) || (st_q == ST_DONE_WT);
  assign tmo_clr = (st_d != st_q);

  cfg_tmo #(.LIMIT(TIMEOUT_CLKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr_i(tmo_clr), .en_i(tmo_en), .hit_o(tmo_hit)
  );

  assign bit_ready_o = (st_q == ST_SHIFT) && !tx_busy && !lastacc_q;
  assign accept      = bit_ready_o && bit_valid_i;

  cfg_bit_tx #(.STEP_CLKS(STEP_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_i(accept), .bit_i(bit_data_i), .last_i(bit_last_i),
    .busy_o(tx_busy), .last_fin_o(tx_last_fin),
    .cclk_o(cclk_o), .cdata_o(cdata_o)
  );

  always_comb begin
    st_d      = st_q;
    err_d     = err_q;
    ok_d      = ok_q;
    lastacc_d = lastacc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_PROG_LO;
          err_d     = ERR_NONE;
          ok_d      = 1'b0;
          lastacc_d = 1'b0;
        end
      end
      ST_PROG_LO: begin
        if (!init_s)      st_d = ST_PROG_HI;
        else if (tmo_hit) begin
          st_d  = ST_IDLE;
          err_d = ERR_INIT_LO;
        end
      end
      ST_PROG_HI: begin
        if (init_s)       st_d = ST_SHIFT;
        else if (tmo_hit) begin
          st_d  = ST_IDLE;
          err_d = ERR_INIT_HI;
        end
      end
      ST_SHIFT: begin
        if (accept && bit_last_i) lastacc_d = 1'b1;
        if (tx_last_fin)          st_d      = ST_DONE_WT;
      end
      ST_DONE_WT: begin
        if (done_s) begin
          st_d = ST_IDLE;
          ok_d = 1'b1;
        end else if (tmo_hit) begin
          st_d  = ST_IDLE;
          err_d = ERR_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      err_q     <= ERR_NONE;
      ok_q      <= 1'b0;
      lastacc_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      err_q     <= err_d;
      ok_q      <= ok_d;
      lastacc_q <= lastacc_d;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign prog_n_o = (st_q != ST_PROG_LO);
  assign ok_o     = ok_q;
  assign err_o    = err_q;

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       bit_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       cdata_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic [1:0] err_o
);

  a_r1_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_n_o && cclk_o && cdata_o));

  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !prog_n_o));

  a_r4_data_high_at_clk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> (cdata_o && $past(cdata_o)));

  a_r4_data_stable_at_clk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(cdata_o));

  a_r5_ready_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready_o |-> (busy_o && prog_n_o && cclk_o));

  a_r6_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (!busy_o && err_o == 2'd0));

  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && prog_n_o && start_i) |=> prog_n_o);

endmodule

bind cfg_load_seq cfg_load_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_ready_o(bit_ready_o),
  .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
  .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
);

// File: tb/tb_cfg_load_seq.sv
`timescale 1ns/1ps
module tb_cfg_load_seq;

  localparam int STEP = 3;
  localparam int TMO  = 64;
  localparam int SYNC = 2;
  localparam int NV   = 8;

  // vector: {fall, rise, done, nbits[3:0], pat[7:0], exp_err[1:0], exp_ok}
  localparam logic [17:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b1, 4'd8, 8'hA5, 2'd0, 1'b1},
    {1'b1, 1'b1, 1'b1, 4'd1, 8'h00, 2'd0, 1'b1},
    {1'b1, 1'b1, 1'b1, 4'd5, 8'hF0, 2'd0, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd1, 8'h00, 2'd1, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd1, 8'h00, 2'd2, 1'b0},
    {1'b1, 1'b1, 1'b0, 4'd3, 8'h60, 2'd3, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd8, 8'h00, 2'd0, 1'b1},
    {1'b1, 1'b1, 1'b1, 4'd8, 8'hFF, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, bit_valid_i = 1'b0, bit_data_i = 1'b0, bit_last_i = 1'b0;
  logic dev_init_i = 1'b1, dev_done_i = 1'b0;
  logic bit_ready_o, prog_n_o, cclk_o, cdata_o, busy_o, ok_o;
  logic [1:0] err_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] cap;
  int cap_n = 0;
  logic prev_cclk = 1'b1;
  int low_len = 0;

  always #2.5 clk = ~clk;

  cfg_load_seq #(.STEP_CLKS(STEP), .TIMEOUT_CLKS(TMO), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .bit_last_i(bit_last_i),
    .bit_ready_o(bit_ready_o), .dev_init_i(dev_init_i), .dev_done_i(dev_done_i),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial monitor: captures bits on clock rise, checks step shape (R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cclk_o) low_len++;
      if (!prev_cclk && cclk_o) begin
        if (cap_n < 16) cap[cap_n] = cdata_o;
        cap_n++;
        check("R4 clock-low length", low_len, 2 * STEP);
      end
      if (prev_cclk && !cclk_o) begin
        low_len = 1;
        check("R4 data high at clock fall", int'(cdata_o), 1);
      end
      prev_cclk = cclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_until_idle();
    for (int g = 0; g < 5000 && busy_o; g++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic l);
    for (int g = 0; g < 5000 && !bit_ready_o; g++) @(negedge clk);
    bit_valid_i = 1'b1; bit_data_i = b; bit_last_i = l;
    @(negedge clk);
    bit_valid_i = 1'b0; bit_last_i = 1'b0;
  endtask

  task automatic run_vec(input logic [17:0] v);
    logic fall, rise, dn, eok;
    logic [3:0] nb;
    logic [7:0] pat;
    logic [1:0] eerr;
    {fall, rise, dn, nb, pat, eerr, eok} = v;
    dev_init_i = 1'b1; dev_done_i = 1'b0; cap_n = 0;
    repeat (SYNC + 2) @(negedge clk);
    pulse_start();
    check("R2 prog low after start", int'(prog_n_o), 0);
    check("R2 busy after start", int'(busy_o), 1);
    if (fall) begin
      repeat (4) @(negedge clk);
      dev_init_i = 1'b0;
      for (int g = 0; g < 500 && !prog_n_o; g++) @(negedge clk);
      check("R3 prog released after init low", int'(prog_n_o && busy_o), 1);
      if (rise) begin
        repeat (4) @(negedge clk);
        dev_init_i = 1'b1;
        for (int i = 0; i < int'(nb); i++) send_bit(pat[7-i], i == int'(nb) - 1);
        if (dn) begin
          repeat (4 * STEP + 4) @(negedge clk);
          dev_done_i = 1'b1;
        end
      end
    end
    wait_until_idle();
    check("R7 error code", int'(err_o), int'(eerr));
    check("R6 ok flag", int'(ok_o), int'(eok));
    check("R1 pins idle after run", int'({prog_n_o, cclk_o, cdata_o}), 7);
    if (fall && rise) begin
      check("R5 bits sent", cap_n, int'(nb));
      for (int i = 0; i < int'(nb); i++)
        check("R4 bit value in order", int'(cap[i]), int'(pat[7-i]));
    end
    if (eok) begin
      repeat (20) @(negedge clk);
      check("R6 ok held", int'(ok_o), 1);
    end
  endtask

  // race between timeout expiry and init edge (R8)
  task automatic race(input int lead, input int exp_err);
    dev_init_i = 1'b1; dev_done_i = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    @(negedge clk) start_i = 1'b0;
    repeat (lead) @(posedge clk);
    @(negedge clk) dev_init_i = 1'b0;
    wait_until_idle();
    check("R8 timeout race outcome", int'(err_o), exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset prog", int'(prog_n_o), 1);
    check("R1 reset cclk/cdata", int'({cclk_o, cdata_o}), 3);
    check("R1 reset status", int'({busy_o, ok_o, bit_ready_o, err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R8: synchronized init seen in the last window cycle wins -> later 10
    race(TMO - 3, 2);
    // one cycle late -> init-fall timeout 01
    race(TMO - 2, 1);

    // R9: start pulse during the data phase is ignored
    dev_init_i = 1'b1; dev_done_i = 1'b0; cap_n = 0;
    repeat (SYNC + 2) @(negedge clk);
    pulse_start();
    repeat (4) @(negedge clk);
    dev_init_i = 1'b0;
    for (int g = 0; g < 500 && !prog_n_o; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    dev_init_i = 1'b1;
    for (int g = 0; g < 500 && !bit_ready_o; g++) @(negedge clk);
    pulse_start();
    for (int k = 0; k < 8; k++) begin
      check("R9 prog stays high on busy start", int'(prog_n_o && busy_o), 1);
      @(negedge clk);
    end
    send_bit(1'b1, 1'b1);
    check("R5 ready drops after last bit", int'(bit_ready_o), 0);
    repeat (4 * STEP + 4) @(negedge clk);
    dev_done_i = 1'b1;
    wait_until_idle();
    check("R9 run completes", int'(ok_o), 1);
    check("R9 single bit sent", cap_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule